// File: doc/BRIEF.md
# Board System Control Register File

This block is the status and control register file of a development board. A host reaches it over a simple 32-bit register bus. The bus carries a 12-bit byte offset, a write strobe, a read strobe, write data and combinational read data. A constant identity word is a parameter, and the block decodes a 12-bit board-type code from it. That code sets the reset value of the display-control register, which of its bits the host may change, whether the reset-level register exists at all, and where the write-protect status lands in the card-slot word.

The file holds these registers:
- LED, scratch-flag and reset-level registers.
- A 16-bit unlock key register, which gates writes to the reset-level register.
- A card-slot status word, sampled every cycle from two input lines.
- A display-control register with a 2-bit format-select output on one board type.
- A 32-bit tick counter, advanced by a 24 MHz tick enable.

A few constant words identify the board and its processor. An access to any offset outside the map returns zero and pulses an error flag for one cycle.

The reset input is asynchronous and active low. Its release passes through a two-flop synchronizer, so registers leave reset on the second rising clock edge after the release.

Top module: `board_sysctl`

## Requirements
- R1: Offset 0x000 reads the identity parameter, 0x044 reads 1, 0x084 reads the processor-ID parameter, and 0x088 reads 0xFF000000. Writes to these offsets change nothing.
- R2: After reset, offsets 0x008 (LED), 0x020 (key), 0x030 (flags), 0x040 (reset level) and 0x05C (tick count) read zero. The key offset reads zero in bits 15:0 and 1 in bit 16.
- R3: A write to 0x020 stores write-data bits 15:0, which read back in bits 15:0. Bit 16 reads 1 exactly when the stored key differs from 0xA05F. All other bits read 0.
- R4: A write to 0x040 loads all 32 bits only while the stored key equals 0xA05F; otherwise it is ignored. When the board type (identity bits 27:16) is 0x190, offset 0x040 always reads zero and ignores writes.
- R5: The display register at 0x050 resets to 0x00001F00, or to 0 when the board type is 0x190.
- R6: For board types 0x100 and 0x140, a write to 0x050 keeps bits 13:8 and takes every other bit from the write data.
- R7: For board types 0x178 and 0x182, a write to 0x050 keeps bit 7 and takes every other bit from the write data.
- R8: For board type 0x190 and for any unrecognised board type, writes to 0x050 are ignored.
- R9: For board type 0x100 only, the format-select output takes write-data bits 1:0 on each write to 0x050, one clock later. It resets to 0 and stays 0 on every other board type.
- R10: Offset 0x048 holds the card-present input in bit 0, sampled one clock earlier. The write-protect input appears in bit 2 for board types 0x100 and 0x140 and in bit 1 otherwise. All other bits read 0.
- R11: Offset 0x05C reads a wrapping counter that increments once per clock in which the tick enable is high and holds otherwise.
- R12: A read or write strobe to an offset outside the map (including misaligned offsets) reads zero, changes no register and raises the error flag for the one following clock. Mapped offsets never raise it.
- R13: Offsets 0x008 and 0x030 store all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, used only for error detection |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset, combinational |
| card_present | input | 1 | Card-slot occupied line |
| write_protect | input | 1 | Card write-protect line |
| tick_24m | input | 1 | 24 MHz tick enable for the counter |
| disp_mux | output | 2 | Display format select |
| bad_access | output | 1 | One-cycle pulse after a strobe to an unmapped offset |

## Verification
Every stored bit is visible through the read port on the cycle after the write that set it. A corrupted mask or a wrong board-type decode therefore shows up as a mismatched read word at the very next read of that offset. The same holds for a key compare that accepts the wrong value. A wrong status-bit position or a wrong counter step likewise shows within one read after the input changes. The bench instantiates the block for all five recognised board types plus one unknown type. After each write pattern it sweeps every aligned offset, so a mask error on one variant cannot hide behind another.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [2:0] {
    BK_926   = 3'd0,
    BK_EB    = 3'd1,
    BK_A8    = 3'd2,
    BK_PBX   = 3'd3,
    BK_VX    = 3'd4,
    BK_OTHER = 3'd5
  } board_kind_e;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  localparam logic [11:0] OFF_ID     = 12'h000;
  localparam logic [11:0] OFF_LED    = 12'h008;
  localparam logic [11:0] OFF_KEY    = 12'h020;
  localparam logic [11:0] OFF_FLAGS  = 12'h030;
  localparam logic [11:0] OFF_RSTLVL = 12'h040;
  localparam logic [11:0] OFF_ONE    = 12'h044;
  localparam logic [11:0] OFF_CARD   = 12'h048;
  localparam logic [11:0] OFF_DISP   = 12'h050;
  localparam logic [11:0] OFF_TICK   = 12'h05C;
  localparam logic [11:0] OFF_PROC0  = 12'h084;
  localparam logic [11:0] OFF_PROC1  = 12'h088;

  function automatic board_kind_e kind_of(input logic [31:0] id);
    case (id[27:16])
      12'h100: return BK_926;
      12'h140: return BK_EB;
      12'h178: return BK_A8;
      12'h182: return BK_PBX;
      12'h190: return BK_VX;
      default: return BK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_keylvl.sv
module sysctl_keylvl
  import sysctl_pkg::*;
#(
  parameter bit ABSENT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        wr_key,
  input  logic        wr_lvl,
  input  logic [31:0] wdata,
  output logic [15:0] key_q,
  output logic        locked,
  output logic [31:0] lvl_q
);

  logic [15:0] key_d;
  logic [31:0] lvl_d;
  logic        lvl_en;

  assign locked = (key_q != UNLOCK_KEY);
  assign lvl_en = wr_lvl && !locked && !ABSENT;

  always_comb begin
    key_d = key_q;
    lvl_d = lvl_q;
    if (wr_key) key_d = wdata[15:0];
    if (lvl_en) lvl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      lvl_q <= '0;
    end else begin
      key_q <= key_d;
      lvl_q <= lvl_d;
    end
  end

  // R3: the key only moves on a write to its offset
  assert_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_key |=> $stable(key_q));

  // R4: reset level only moves on a write while unlocked
  assert_lvl_gate_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_lvl || key_q != UNLOCK_KEY) |=> $stable(lvl_q));

endmodule

// File: rtl/sysctl_disp.sv
module sysctl_disp
  import sysctl_pkg::*;
#(
  parameter board_kind_e KIND = BK_OTHER
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] disp_q,
  output logic [1:0]  mux_q
);

  localparam logic [31:0] RST_VAL = (KIND == BK_VX) ? 32'h0 : 32'h0000_1F00;
  localparam logic [31:0] KEEP =
    (KIND == BK_926 || KIND == BK_EB) ? 32'h0000_3F00 :
    (KIND == BK_A8  || KIND == BK_PBX) ? 32'h0000_0080 : 32'hFFFF_FFFF;
  localparam bit HAS_MUX = (KIND == BK_926);

  logic [31:0] disp_d;
  logic [1:0]  mux_d;

  always_comb begin
    disp_d = disp_q;
    mux_d  = mux_q;
    if (wr) begin
      disp_d = (disp_q & KEEP) | (wdata & ~KEEP);
      if (HAS_MUX) mux_d = wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= RST_VAL;
      mux_q  <= 2'b00;
    end else begin
      disp_q <= disp_d;
      mux_q  <= mux_d;
    end
  end

  // R6, R7, R8: the protected bits of this variant never change
  assert_keep_bits_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((disp_q & KEEP) == ($past(disp_q) & KEEP)));

  // R9: the select output only moves on a display write
  assert_mux_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr |=> $stable(mux_q));

endmodule

// File: rtl/sysctl_ticker.sv
module sysctl_ticker #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_tick_step_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/board_sysctl.sv
module board_sysctl
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h0190_0000,
  parameter logic [31:0] PROC_ID = 32'h0C00_0000,
  parameter int          CNT_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        card_present,
  input  logic        write_protect,
  input  logic        tick_24m,
  output logic [1:0]  disp_mux,
  output logic        bad_access
);

  localparam board_kind_e KIND   = kind_of(ID_WORD);
  localparam int          WP_BIT = (KIND == BK_926 || KIND == BK_EB) ? 2 : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // address decode
  logic hit;
  logic wr_led, wr_key, wr_flags, wr_lvl, wr_disp;

  always_comb begin
    case (reg_addr)
      OFF_ID, OFF_LED, OFF_KEY, OFF_FLAGS, OFF_RSTLVL, OFF_ONE,
      OFF_CARD, OFF_DISP, OFF_TICK, OFF_PROC0, OFF_PROC1: hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

  assign wr_led   = reg_wr && (reg_addr == OFF_LED);
  assign wr_key   = reg_wr && (reg_addr == OFF_KEY);
  assign wr_flags = reg_wr && (reg_addr == OFF_FLAGS);
  assign wr_lvl   = reg_wr && (reg_addr == OFF_RSTLVL);
  assign wr_disp  = reg_wr && (reg_addr == OFF_DISP);

  // simple storage: LED, flags, card status, error flag
  logic [31:0] led_q, led_d, flags_q, flags_d;
  logic [2:0]  stat_q, stat_d;
  logic        bad_d;

  always_comb begin
    led_d   = wr_led   ? reg_wdata : led_q;
    flags_d = wr_flags ? reg_wdata : flags_q;
    stat_d  = 3'b000;
    stat_d[0]      = card_present;
    stat_d[WP_BIT] = write_protect;
    bad_d   = (reg_wr || reg_rd) && !hit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q      <= '0;
      flags_q    <= '0;
      stat_q     <= '0;
      bad_access <= 1'b0;
    end else begin
      led_q      <= led_d;
      flags_q    <= flags_d;
      stat_q     <= stat_d;
      bad_access <= bad_d;
    end
  end

  // submodules
  logic [15:0]      key_q;
  logic             locked;
  logic [31:0]      lvl_q;
  logic [31:0]      disp_q;
  logic [CNT_W-1:0] cnt_q;

  sysctl_keylvl #(.ABSENT(KIND == BK_VX)) u_keylvl (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_key (wr_key),
    .wr_lvl (wr_lvl),
    .wdata  (reg_wdata),
    .key_q  (key_q),
    .locked (locked),
    .lvl_q  (lvl_q)
  );

  sysctl_disp #(.KIND(KIND)) u_disp (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr     (wr_disp),
    .wdata  (reg_wdata),
    .disp_q (disp_q),
    .mux_q  (disp_mux)
  );

  sysctl_ticker #(.CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tick   (tick_24m),
    .cnt_q  (cnt_q)
  );

  // read multiplexer
  always_comb begin
    case (reg_addr)
      OFF_ID:     reg_rdata = ID_WORD;
      OFF_LED:    reg_rdata = led_q;
      OFF_KEY:    reg_rdata = {15'b0, locked, key_q};
      OFF_FLAGS:  reg_rdata = flags_q;
      OFF_RSTLVL: reg_rdata = (KIND == BK_VX) ? 32'h0 : lvl_q;
      OFF_ONE:    reg_rdata = 32'h1;
      OFF_CARD:   reg_rdata = {29'b0, stat_q};
      OFF_DISP:   reg_rdata = disp_q;
      OFF_TICK:   reg_rdata = 32'(cnt_q);
      OFF_PROC0:  reg_rdata = PROC_ID;
      OFF_PROC1:  reg_rdata = 32'hFF00_0000;
      default:    reg_rdata = 32'h0;
    endcase
  end

  // R12: an unmapped strobe raises the error flag on the next clock
  assert_bad_pulse_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    ((reg_wr || reg_rd) && !hit) |=> bad_access);

  // R12: no flag without a strobe
  assert_bad_quiet_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !(reg_wr || reg_rd) |=> !bad_access);

  // R10: card-present bit follows the input by one clock
  assert_card_bit_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (stat_q[0] == $past(card_present)));

  // R13: LED register only moves on its own write
  assert_led_hold_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_led |=> $stable(led_q));

endmodule

// File: tb/sim_board_sysctl.sv
module sim_board_sysctl;

  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic        card = 1'b0;
  logic        wp = 1'b0;
  logic        tick = 1'b0;

  logic [31:0] rd_a  [NDUT];
  logic [1:0]  mux_a [NDUT];
  logic        bad_a [NDUT];

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] bt_of(input int g);
    case (g)
      0: return 12'h100;
      1: return 12'h140;
      2: return 12'h178;
      3: return 12'h182;
      4: return 12'h190;
      default: return 12'h2AB;
    endcase
  endfunction

  function automatic logic [31:0] idw(input int g);
    return {4'h2, bt_of(g), 16'h5A00 + 16'(g)};
  endfunction

  function automatic logic [31:0] pidw(input int g);
    return 32'h0C00_0000 + 32'(g);
  endfunction

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    board_sysctl #(.ID_WORD(idw(g)), .PROC_ID(pidw(g)), .CNT_W(32)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_addr      (addr),
      .reg_wr        (wr),
      .reg_rd        (rd),
      .reg_wdata     (wdata),
      .reg_rdata     (rd_a[g]),
      .card_present  (card),
      .write_protect (wp),
      .tick_24m      (tick),
      .disp_mux      (mux_a[g]),
      .bad_access    (bad_a[g])
    );
  end

  // reference model
  logic [31:0] m_led, m_flags, m_cnt;
  logic [15:0] m_key;
  logic [31:0] m_lvl  [NDUT];
  logic [31:0] m_disp [NDUT];
  logic [1:0]  m_mux  [NDUT];

  task automatic model_reset();
    m_led = 0; m_flags = 0; m_cnt = 0; m_key = 0;
    for (int i = 0; i < NDUT; i++) begin
      m_lvl[i]  = 0;
      m_disp[i] = (bt_of(i) == 12'h190) ? 32'h0 : 32'h1F00;
      m_mux[i]  = 0;
    end
  endtask

  function automatic bit mapped(input logic [11:0] a);
    case (a)
      12'h000, 12'h008, 12'h020, 12'h030, 12'h040, 12'h044,
      12'h048, 12'h050, 12'h05C, 12'h084, 12'h088: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h000, 12'h044, 12'h084, 12'h088: return "R1";
      12'h008, 12'h030: return "R13";
      12'h020: return "R3";
      12'h040: return "R4";
      12'h048: return "R10";
      12'h050: return "R6/R7/R8";
      12'h05C: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] expv(input int i, input logic [11:0] a);
    logic [11:0] t;
    t = bt_of(i);
    case (a)
      12'h000: return idw(i);
      12'h008: return m_led;
      12'h020: return {15'b0, (m_key != 16'hA05F), m_key};
      12'h030: return m_flags;
      12'h040: return (t == 12'h190) ? 32'h0 : m_lvl[i];
      12'h044: return 32'h1;
      12'h048: return (t == 12'h100 || t == 12'h140) ? {29'b0, wp, 1'b0, card}
                                                      : {30'b0, wp, card};
      12'h050: return m_disp[i];
      12'h05C: return m_cnt;
      12'h084: return pidw(i);
      12'h088: return 32'hFF00_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    logic [11:0] t;
    for (int i = 0; i < NDUT; i++) begin
      t = bt_of(i);
      if (a == 12'h040 && t != 12'h190 && m_key == 16'hA05F) m_lvl[i] = d;
      if (a == 12'h050) begin
        if (t == 12'h100 || t == 12'h140)
          m_disp[i] = (m_disp[i] & 32'h3F00) | (d & ~32'h3F00);
        else if (t == 12'h178 || t == 12'h182)
          m_disp[i] = (m_disp[i] & 32'h80) | (d & ~32'h80);
        if (t == 12'h100) m_mux[i] = d[1:0];
      end
    end
    if (a == 12'h008) m_led = d;
    if (a == 12'h030) m_flags = d;
    if (a == 12'h020) m_key = d[15:0];
  endtask

  task automatic check(input string req, input int i, input logic [31:0] act,
                       input logic [31:0] exp, input logic [11:0] a);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s dut%0d off 0x%03h: actual 0x%08h expected 0x%08h",
               req, i, a, act, exp);
    end
  endtask

  // read every aligned offset on every variant, no strobe
  task automatic sweep_reads();
    for (int a = 0; a < 256; a += 4) begin
      @(negedge clk);
      addr = 12'(a);
      #1;
      for (int i = 0; i < NDUT; i++)
        check(req_of(12'(a)), i, rd_a[i], expv(i, 12'(a)), 12'(a));
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
    for (int i = 0; i < NDUT; i++) begin
      check("R12", i, 32'(bad_a[i]), 32'(!mapped(a)), a);
      check("R9", i, 32'(mux_a[i]), 32'(m_mux[i]), a);
    end
  endtask

  task automatic do_rd_strobe(input logic [11:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    for (int i = 0; i < NDUT; i++) check("R12", i, rd_a[i], expv(i, a), a);
    @(negedge clk);
    rd = 1'b0;
    for (int i = 0; i < NDUT; i++)
      check("R12", i, 32'(bad_a[i]), 32'(!mapped(a)), a);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5C3_3C5A, 32'h1234_5678};
    apply_reset();
    // R2, R5: reset state everywhere
    sweep_reads();
    for (int i = 0; i < NDUT; i++) check("R9", i, 32'(mux_a[i]), 32'h0, 12'h050);

    // write every offset with several patterns, then read all back
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 256; a += 4)
        do_wr(12'(a), pats[p] ^ 32'(a));
      sweep_reads();
    end

    // R4: key gating of reset level
    do_wr(12'h020, 32'hFFFF_A05F);
    do_wr(12'h040, 32'hDEAD_0101);
    sweep_reads();
    do_wr(12'h020, 32'h0000_A05E);
    do_wr(12'h040, 32'h1234_0000);
    sweep_reads();

    // R6..R9: display writes with each select value
    for (int v = 0; v < 4; v++) do_wr(12'h050, 32'hFFFF_C07C | 32'(v));
    sweep_reads();

    // R12: misaligned and out-of-map strobes, mapped read strobes
    do_wr(12'h042, 32'hFFFF_FFFF);
    do_wr(12'h800, 32'hFFFF_FFFF);
    do_rd_strobe(12'h041);
    do_rd_strobe(12'hFFC);
    do_rd_strobe(12'h048);
    do_rd_strobe(12'h000);
    sweep_reads();

    // R10: all input combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      card = c[0]; wp = c[1];
      @(negedge clk);
      addr = 12'h048;
      #1;
      for (int i = 0; i < NDUT; i++)
        check("R10", i, rd_a[i], expv(i, 12'h048), 12'h048);
    end

    // R11: tick counting
    @(negedge clk);
    tick = 1'b1;
    repeat (37) @(negedge clk);
    tick = 1'b0;
    m_cnt = m_cnt + 37;
    repeat (3) @(negedge clk);
    addr = 12'h05C;
    #1;
    for (int i = 0; i < NDUT; i++)
      check("R11", i, rd_a[i], expv(i, 12'h05C), 12'h05C);

    // R2: mid-run reset restores the reset state
    apply_reset();
    sweep_reads();
    for (int i = 0; i < NDUT; i++) check("R2", i, 32'(mux_a[i]), 32'h0, 12'h050);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule